// File: doc/BRIEF.md
# Oversampled Serial Receiver with Active-Edge Flag

This block is the receive half of an asynchronous serial port. A programmable divisor sets how many clock cycles make one receive tick, and sixteen ticks make one bit. After a start condition is seen, the receiver takes three samples around the centre of each bit and decides the bit by majority. It then assembles a frame of one start bit, eight data bits and one stop bit, and reports the byte with framing and noise status.

A polarity input selects which line level is idle. The same choice applies to the data path and to the edge detector. An infrared mode accepts a short pulse in place of a full-width zero bit. An edge flag is set on every active line edge and is cleared by a write-one-to-clear strobe. The flag keeps working while a stop input holds the receiver asleep, and in that state it drives a wake request.

Top module: `osrx_top`

## Requirements
- R1: One tick occurs every `divisor_i` clock cycles (values 0 and 1 both give one tick per cycle). A bit lasts 16 ticks, and tick counting restarts when a start condition is detected.
- R2: Each bit is decided by majority over the samples taken at ticks 8, 9 and 10 of that bit. `noise_o` is 1 alongside the byte when the three samples of any bit in the frame disagree.
- R3: A start condition whose majority at ticks 8 to 10 is not the start level is dropped, and the receiver returns to idle without producing a byte.
- R4: A frame is a start bit at the non-idle level, 8 data bits least significant first, and a stop bit that should be at the idle level. A non-idle stop bit still delivers the byte, with `frame_err_o` set to 1.
- R5: With `polarity_i`=0 the line idles high, and the falling edge is the active edge. With `polarity_i`=1 the line is inverted for both reception and edge detection: it idles low, and the rising edge is active. The inactive edge never sets the flag.
- R6: `edge_flag_o` is set by every active edge of the line after a two-stage resynchronizer. It is 0 after reset.
- R7: A one-cycle pulse on `flag_clr_i` clears `edge_flag_o`. When an active edge is detected in the same cycle as the clear, the flag stays set.
- R8: With `ir_mode_i`=1, an active-level pulse of at least 3/16 of a bit, starting at the beginning of the bit, decodes as 0. A bit with no pulse decodes as 1.
- R9: While `stop_i`=1 the receiver is held idle and delivers no byte, but the edge flag still works. `wake_o` is 1 exactly when `stop_i`=1 and the flag is set.
- R10: Two active edges 4 clock cycles apart are detected as two separate edges.
- R11: `data_valid_o` is a one-cycle pulse. `data_o` holds the last byte until the next one arrives and reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line |
| divisor_i | input | DIV_W | Clock cycles per receive tick |
| polarity_i | input | 1 | 0: idle high, falling edge active; 1: inverted |
| ir_mode_i | input | 1 | Infrared pulse decoding |
| stop_i | input | 1 | Low-power stop; holds the receiver idle |
| flag_clr_i | input | 1 | Write-one-to-clear for the edge flag |
| data_valid_o | output | 1 | Byte ready pulse |
| data_o | output | DATA_W | Received byte |
| frame_err_o | output | 1 | Stop bit error, valid with data_valid_o |
| noise_o | output | 1 | Sample disagreement, valid with data_valid_o |
| edge_flag_o | output | 1 | Sticky active-edge flag |
| wake_o | output | 1 | Wake request during stop |

## Verification
The hardest cases to reach are a disagreement among the three centre samples and an edge that lands in the same cycle as a clear. Both depend on exact cycle placement seen only through the resynchronizer. Because the tick phase restarts at start detection, a glitch one tick wide placed 8.5 ticks into a chosen data bit hits only the middle sample. The clear strobe is driven two cycles after the line change, so it meets the detected edge in the same cycle. A second line pulse 4 cycles after the first, with a clear in between, shows that close edges are seen separately.

// File: rtl/osrx_pkg.sv
package osrx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic disagree3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction
endpackage

// File: rtl/osrx_tick_gen.sv
module osrx_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (divisor_i == '0) ? '0 : divisor_i - 1'b1;
  assign tick_o = run_i && (cnt_q >= lim);

  // phase restarts whenever the receiver is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/osrx_line_front.sv
module osrx_line_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic polarity_i,
  input  logic clr_i,
  output logic line_o,
  output logic edge_o,
  output logic flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // polarity applied before the synchronizer: line_o is always idle-high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i ^ polarity_i};
  end

  assign line_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= line_o;
  end

  assign edge_o = prev_q & ~line_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (edge_o) flag_o <= 1'b1;   // edge wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r6_edge_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> flag_o);
  a_r7_clear_without_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !edge_o) |=> !flag_o);
endmodule

// File: rtl/osrx_ir_decode.sv
module osrx_ir_decode #(
  parameter int STRETCH = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_mode_i,
  input  logic flush_i,
  input  logic tick_i,
  input  logic line_i,
  output logic line_o
);
  localparam int SW = $clog2(STRETCH + 1);

  logic [SW-1:0] cnt_q;

  // a short low pulse is widened to cover the mid-bit samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (flush_i)                 cnt_q <= '0;
    else if (!line_i)                 cnt_q <= SW'(STRETCH);
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign line_o = ir_mode_i ? (line_i && (cnt_q == '0)) : line_i;
endmodule

// File: rtl/osrx_frame.sv
module osrx_frame
  import osrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o,
  output logic              noise_o
);
  localparam int TW = $clog2(OSR + 1);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TW-1:0] T_S0  = TW'(OSR / 2);
  localparam logic [TW-1:0] T_S2  = TW'(OSR / 2 + 2);
  localparam logic [TW-1:0] T_END = TW'(OSR);

  rx_state_e         state_q;
  logic [TW-1:0]     tcnt_q, tnext;
  logic [BW-1:0]     bcnt_q;
  logic [1:0]        samp_q;
  logic [DATA_W-1:0] shreg_q;
  logic              nacc_q;
  logic              in_win, last_smp, vote, nz;

  assign tnext    = tcnt_q + 1'b1;
  assign in_win   = tick_i && (tnext >= T_S0) && (tnext <= T_S2);
  assign last_smp = tick_i && (tnext == T_S2);
  assign vote     = maj3(samp_q[1], samp_q[0], line_i);
  assign nz       = disagree3(samp_q[1], samp_q[0], line_i);
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      samp_q  <= '0;
      shreg_q <= '0;
      nacc_q  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
      noise_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      noise_o <= 1'b0;
      if (hold_i) begin
        state_q <= ST_IDLE;
        tcnt_q  <= '0;
      end else if (state_q == ST_IDLE) begin
        if (!line_i) begin
          state_q <= ST_START;
          tcnt_q  <= '0;
          nacc_q  <= 1'b0;
        end
      end else if (tick_i) begin
        tcnt_q <= (tnext == T_END) ? '0 : tnext;
        if (in_win) samp_q <= {samp_q[0], line_i};
        if (last_smp) begin
          unique case (state_q)
            ST_START: begin
              nacc_q <= nz;
              if (vote) state_q <= ST_IDLE;   // false start
            end
            ST_DATA: begin
              shreg_q <= {vote, shreg_q[DATA_W-1:1]};
              nacc_q  <= nacc_q | nz;
            end
            ST_STOP: begin
              valid_o <= 1'b1;
              data_o  <= shreg_q;
              ferr_o  <= !vote;
              noise_o <= nacc_q | nz;
              state_q <= ST_IDLE;
            end
            default: ;
          endcase
        end
        if (tnext == T_END) begin
          if (state_q == ST_START) begin
            state_q <= ST_DATA;
            bcnt_q  <= '0;
          end else if (state_q == ST_DATA) begin
            if (bcnt_q == BW'(DATA_W - 1)) state_q <= ST_STOP;
            else                            bcnt_q  <= bcnt_q + 1'b1;
          end
        end
      end
    end
  end

  a_r11_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r4_ferr_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_o |-> valid_o);
  a_r1_tick_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcnt_q < T_END);
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!valid_o && !busy_o));
endmodule

// File: rtl/osrx_top.sv
module osrx_top #(
  parameter int DIV_W       = 12,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IR_STRETCH  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              polarity_i,
  input  logic              ir_mode_i,
  input  logic              stop_i,
  input  logic              flag_clr_i,
  output logic              data_valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              noise_o,
  output logic              edge_flag_o,
  output logic              wake_o
);
  logic line_s, line_d, edge_w, tick_w, busy_w;

  osrx_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .rxd_i, .polarity_i,
    .clr_i  (flag_clr_i),
    .line_o (line_s),
    .edge_o (edge_w),
    .flag_o (edge_flag_o)
  );

  osrx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni,
    .run_i  (busy_w),
    .divisor_i,
    .tick_o (tick_w)
  );

  osrx_ir_decode #(.STRETCH(IR_STRETCH)) u_ir (
    .clk_i, .rst_ni, .ir_mode_i,
    .flush_i (stop_i | ~ir_mode_i),
    .tick_i  (tick_w),
    .line_i  (line_s),
    .line_o  (line_d)
  );

  osrx_frame #(.DATA_W(DATA_W), .OSR(16)) u_frame (
    .clk_i, .rst_ni,
    .hold_i  (stop_i),
    .tick_i  (tick_w),
    .line_i  (line_d),
    .busy_o  (busy_w),
    .valid_o (data_valid_o),
    .data_o,
    .ferr_o  (frame_err_o),
    .noise_o
  );

  assign wake_o = stop_i & edge_flag_o;

  a_r9_wake_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && edge_w) |=> (wake_o || !stop_i));
endmodule

// File: tb/osrx_top_bench.sv
module osrx_top_bench;
  localparam int DIV_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, pol = 1'b0, ir = 1'b0, stop = 1'b0, clr = 1'b0;
  logic [DIV_W-1:0] divisor = 12'd8;
  logic data_valid, frame_err, noise, flag, wake;
  logic [7:0] data;

  always #10 clk = ~clk;

  osrx_top u_osrx_top (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .divisor_i(divisor),
    .polarity_i(pol), .ir_mode_i(ir), .stop_i(stop), .flag_clr_i(clr),
    .data_valid_o(data_valid), .data_o(data), .frame_err_o(frame_err),
    .noise_o(noise), .edge_flag_o(flag), .wake_o(wake)
  );

  typedef struct packed { logic [7:0] d; logic fe; logic nz; } exp_t;
  exp_t q[$];
  exp_t mon_e;
  int errors = 0, checks = 0, rx_count = 0, base = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every delivered byte
  always @(negedge clk) begin
    if (rst_n && data_valid) begin
      rx_count++;
      if (q.size() == 0) chk(1'b0, "R3", "unexpected byte", {24'd0, data}, 32'd0);
      else begin
        mon_e = q.pop_front();
        chk(data == mon_e.d, "R4", "data", {24'd0, data}, {24'd0, mon_e.d});
        chk(frame_err == mon_e.fe, "R4", "frame_err", {31'd0, frame_err}, {31'd0, mon_e.fe});
        chk(noise == mon_e.nz, "R2", "noise", {31'd0, noise}, {31'd0, mon_e.nz});
      end
    end
  end

  task automatic hold_line(input bit v, input int n);
    rxd = v ^ pol;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit v, input bit glitch);
    int bt = 16 * int'(divisor);
    int dv = int'(divisor);
    if (ir) begin
      if (!v) begin hold_line(1'b0, 3 * dv); hold_line(1'b1, bt - 3 * dv); end
      else hold_line(1'b1, bt);
    end else if (glitch) begin
      hold_line(v, 8 * dv + dv / 2);
      hold_line(!v, dv);
      hold_line(v, bt - 9 * dv - dv / 2);
    end else hold_line(v, bt);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit stopv, input int gbit,
                            input bit expect_it);
    exp_t e;
    if (expect_it) begin
      e.d = d; e.fe = !stopv; e.nz = (gbit >= 0);
      q.push_back(e);
    end
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i], i == gbit);
    send_bit(stopv, 1'b0);
    hold_line(1'b1, 32 * int'(divisor));
  endtask

  task automatic drain();
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_pulse();
    clr = 1'b1; @(negedge clk);
    clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!data_valid, "R11", "valid in reset", {31'd0, data_valid}, 0);
    chk(data == 8'h00, "R11", "data in reset", {24'd0, data}, 0);
    chk(!flag, "R6", "flag in reset", {31'd0, flag}, 0);
    chk(!wake, "R9", "wake in reset", {31'd0, wake}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 R1: plain frames at divisor 8
    send_frame(8'hA5, 1'b1, -1, 1'b1);
    send_frame(8'h00, 1'b1, -1, 1'b1);
    send_frame(8'hFF, 1'b1, -1, 1'b1);
    send_frame(8'h3C, 1'b1, -1, 1'b1);
    drain();
    chk(rx_count == 4, "R4", "frame count", rx_count, 4);
    repeat (50) @(negedge clk);
    chk(data == 8'h3C, "R11", "data held", {24'd0, data}, 32'h3C);
    chk(flag, "R6", "flag after frames", {31'd0, flag}, 1);

    // R2: glitch on middle sample of bit 3
    send_frame(8'h5A, 1'b1, 3, 1'b1);
    // R4: bad stop bit
    send_frame(8'h81, 1'b0, -1, 1'b1);
    drain();

    // R3: false start
    base = rx_count;
    hold_line(1'b0, 3 * int'(divisor));
    hold_line(1'b1, 48 * int'(divisor));
    chk(rx_count == base, "R3", "false start bytes", rx_count, base);
    send_frame(8'h42, 1'b1, -1, 1'b1);
    drain();

    // R1: other divisor
    divisor = 12'd5;
    send_frame(8'hC3, 1'b1, -1, 1'b1);
    drain();
    divisor = 12'd8;

    // R7: clear alone, then edge coinciding with clear
    clr_pulse();
    chk(!flag, "R7", "clear", {31'd0, flag}, 0);
    rxd = 1'b0;               // N0
    @(negedge clk);           // N1
    @(negedge clk);           // N2
    clr = 1'b1;
    @(negedge clk);           // N3
    clr = 1'b0; rxd = 1'b1;
    chk(flag, "R7", "edge beats clear", {31'd0, flag}, 1);
    hold_line(1'b1, 32 * int'(divisor));

    // R10: two edges 4 cycles apart
    clr_pulse();
    rxd = 1'b0;               // N0
    @(negedge clk);           // N1
    @(negedge clk);           // N2
    rxd = 1'b1;
    @(negedge clk);           // N3
    clr = 1'b1;
    @(negedge clk);           // N4
    clr = 1'b0;
    chk(!flag, "R10", "cleared between edges", {31'd0, flag}, 0);
    rxd = 1'b0;
    @(negedge clk);           // N5
    @(negedge clk);           // N6
    rxd = 1'b1;
    @(negedge clk);           // N7
    chk(flag, "R10", "second edge", {31'd0, flag}, 1);
    hold_line(1'b1, 32 * int'(divisor));

    // R5: inverted polarity
    pol = 1'b1;
    hold_line(1'b1, 8);
    clr_pulse();
    hold_line(1'b0, 4);       // raw rising: active
    chk(flag, "R5", "rising active", {31'd0, flag}, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    hold_line(1'b1, 4);       // raw falling: inactive
    chk(!flag, "R5", "falling inactive", {31'd0, flag}, 0);
    hold_line(1'b1, 32 * int'(divisor));
    send_frame(8'h96, 1'b1, -1, 1'b1);
    drain();
    pol = 1'b0;
    hold_line(1'b1, 8);

    // R8: infrared pulses
    ir = 1'b1;
    hold_line(1'b1, 8);
    send_frame(8'h6D, 1'b1, -1, 1'b1);
    send_frame(8'h00, 1'b1, -1, 1'b1);
    drain();
    ir = 1'b0;
    hold_line(1'b1, 8);

    // R9: stop mode
    chk(flag && !wake, "R9", "no wake when running", {31'd0, wake}, 0);
    stop = 1'b1;
    clr_pulse();
    base = rx_count;
    send_frame(8'h77, 1'b1, -1, 1'b0);
    chk(rx_count == base, "R9", "no byte in stop", rx_count, base);
    chk(flag, "R9", "flag in stop", {31'd0, flag}, 1);
    chk(wake, "R9", "wake in stop", {31'd0, wake}, 1);
    clr_pulse();
    chk(!wake, "R9", "wake cleared", {31'd0, wake}, 0);
    stop = 1'b0;
    hold_line(1'b1, 8);
    send_frame(8'h11, 1'b1, -1, 1'b1);
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule